// File: doc/BRIEF.md
# CPU Clock Select and Standby Controller

This block produces the machine-cycle enable for a small microcontroller core. It runs entirely on one fast system clock. Two single-cycle tick inputs mark the edges of a fast main oscillator and a slow subsystem oscillator. A divider chain counts ticks of the selected source and emits one `cpu_en` pulse per machine cycle. The core uses that pulse as a clock enable, so no gated clock is involved.

Two small control registers set the rate. The processor clock register selects the main-clock divide ratio, and its upper two bits show the HALT and STOP standby flags. The system clock register selects the main or the subsystem source, and it can switch the main oscillator off. A HALT request freezes the CPU enable while both oscillators keep running. A STOP request also asserts the main oscillator disable output. Release comes from the interrupt controller's standby-release pulse or from reset. After a STOP, the core stays held until the interval timer signals that the oscillator has settled. A requested change of rate or source is applied only at a machine-cycle boundary, so the core never sees a shortened cycle.

Top module: `cpu_clk_ctrl`

## Requirements
- R1: After reset, `pcc_o` reads 0 and `scc_o` reads 0. The main source is selected at 64 main ticks per cycle, `main_osc_dis` is low, and no standby flag is set.
- R2: With the main source selected, `pcc_o[1:0]` sets the number of main ticks per `cpu_en` pulse. Code 2'b11 gives 4, 2'b10 gives 8, and 2'b00 gives 64. The reserved code 2'b01 also gives 64.
- R3: When `scc_o[0]` is 1, the subsystem source is selected and `cpu_en` pulses once every 4 subsystem ticks.
- R4: A change of divide code or source takes effect at the next machine-cycle boundary. Every interval between `cpu_en` pulses is the full length of either the old setting or the new one, and `cpu_en` is never high for two consecutive cycles.
- R5: A `halt_req` pulse sets the HALT flag (`pcc_o[2]`). While the flag is set, no `cpu_en` pulse occurs, and `main_osc_dis` is left unchanged.
- R6: An `irq_release` pulse clears both HALT (`pcc_o[2]`) and STOP (`pcc_o[3]`) on the next clock. When a request and a release arrive in the same cycle, the release wins.
- R7: A `stop_req` pulse sets the STOP flag (`pcc_o[3]`) and asserts `main_osc_dis`. While it is set, main ticks are ignored and no `cpu_en` pulse occurs.
- R8: After STOP is released by `irq_release`, `cpu_en` stays low until a `wait_release` pulse arrives. After that pulse, it resumes at the programmed rate.
- R9: Bit 3 of the system clock register (`scc_o[3]`) drives `main_osc_dis` directly. With the main source selected, this stops `cpu_en`. With the subsystem source selected, `cpu_en` keeps running at the subsystem rate.
- R10: A write to the processor clock register changes only bits 1:0, and write data bits 3:2 are ignored. A write to the system clock register keeps only bits 0 and 3, and `scc_o[2:1]` always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_tick | input | 1 | One-cycle pulse per main oscillator period |
| sub_tick | input | 1 | One-cycle pulse per subsystem oscillator period |
| pcc_we | input | 1 | Write strobe, processor clock register |
| pcc_wdata | input | 4 | Write data, processor clock register |
| scc_we | input | 1 | Write strobe, system clock register |
| scc_wdata | input | 4 | Write data, system clock register |
| halt_req | input | 1 | HALT instruction executed |
| stop_req | input | 1 | STOP instruction executed |
| irq_release | input | 1 | Standby release from interrupt controller |
| wait_release | input | 1 | Oscillator-settled signal from interval timer |
| cpu_en | output | 1 | Machine-cycle enable, one cycle wide |
| main_osc_dis | output | 1 | Main oscillator disable |
| pcc_o | output | 4 | Processor clock register: {STOP, HALT, divide code} |
| scc_o | output | 4 | System clock register: {osc off, 0, 0, subsystem select} |

## Verification
The bench changes the divide code a few cycles after a machine-cycle boundary and checks the following interval. A design that applied the change at once would show a short first interval instead of one full old interval followed by full new ones. It runs the subsystem source with the main oscillator switched off, where a design that gated the wrong tick would stall. It also sends a HALT request and a release in the same cycle, where a design with set-over-clear priority would leave the core halted with no pending wakeup. After a STOP release, it waits a long stretch without the settle signal, where a design that resumed on the interrupt alone would pulse `cpu_en` before the oscillator is stable.

// File: rtl/clkc_pkg.sv
`timescale 1ns/1ps
package clkc_pkg;

  // Main-clock divide code held in the processor clock register bits 1:0
  typedef enum logic [1:0] {
    MDIV_SLOW = 2'b00,
    MDIV_RSVD = 2'b01,
    MDIV_MID  = 2'b10,
    MDIV_FAST = 2'b11
  } mdiv_e;

  typedef struct packed {
    logic  src_sub;
    mdiv_e mdiv;
  } clk_cfg_t;

  localparam clk_cfg_t CFG_RESET = '{src_sub: 1'b0, mdiv: MDIV_SLOW};

  // Ticks of the chosen source per machine cycle
  function automatic int unsigned cycle_ticks(
    input clk_cfg_t    cfg,
    input int unsigned n_fast,
    input int unsigned n_mid,
    input int unsigned n_slow,
    input int unsigned n_sub
  );
    if (cfg.src_sub) return n_sub;
    case (cfg.mdiv)
      MDIV_FAST: return n_fast;
      MDIV_MID:  return n_mid;
      default:   return n_slow;
    endcase
  endfunction

endpackage

// File: rtl/clkc_regs.sv
`timescale 1ns/1ps
module clkc_regs
  import clkc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pcc_we,
  input  logic [1:0] pcc_div_wdata,
  input  logic       scc_we,
  input  logic       scc_src_wdata,
  input  logic       scc_off_wdata,
  output clk_cfg_t   cfg_req,
  output logic       osc_off
);

  clk_cfg_t cfg_d;
  logic     osc_off_d;

  always_comb begin
    cfg_d     = cfg_req;
    osc_off_d = osc_off;
    if (pcc_we) cfg_d.mdiv = mdiv_e'(pcc_div_wdata);
    if (scc_we) begin
      cfg_d.src_sub = scc_src_wdata;
      osc_off_d     = scc_off_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_req <= CFG_RESET;
      osc_off <= 1'b0;
    end else begin
      cfg_req <= cfg_d;
      osc_off <= osc_off_d;
    end
  end

  // R10: an idle cycle leaves both registers untouched
  a_r10_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!pcc_we && !scc_we) |=> ($stable(cfg_req) && $stable(osc_off)));

endmodule

// File: rtl/clkc_divider.sv
`timescale 1ns/1ps
module clkc_divider
  import clkc_pkg::*;
#(
  parameter int unsigned N_FAST = 4,
  parameter int unsigned N_MID  = 8,
  parameter int unsigned N_SLOW = 64,
  parameter int unsigned N_SUB  = 4,
  localparam int unsigned N_MAX = (N_SLOW > N_SUB) ? N_SLOW : N_SUB,
  localparam int unsigned CNT_W = $clog2(N_MAX)
)(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick_main,
  input  logic     tick_sub,
  input  clk_cfg_t cfg_req,
  output logic     boundary
);

  clk_cfg_t         act_cfg, act_cfg_d;
  logic [CNT_W-1:0] cnt, cnt_d;
  logic [CNT_W-1:0] term;
  logic             tick;

  always_comb begin
    tick = act_cfg.src_sub ? tick_sub : tick_main;
    term = CNT_W'(cycle_ticks(act_cfg, N_FAST, N_MID, N_SLOW, N_SUB) - 1);
    boundary  = tick && (cnt == term);
    cnt_d     = cnt;
    act_cfg_d = act_cfg;
    if (boundary) begin
      cnt_d     = '0;
      act_cfg_d = cfg_req;
    end else if (tick) begin
      cnt_d = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      act_cfg <= CFG_RESET;
    end else begin
      cnt     <= cnt_d;
      act_cfg <= act_cfg_d;
    end
  end

  // R4: the applied setting moves only on a machine-cycle boundary
  a_r4_cfg_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(act_cfg));

  // R4: the counter never runs past the active terminal value
  a_r4_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= term);

endmodule

// File: rtl/clkc_standby.sv
`timescale 1ns/1ps
module clkc_standby (
  input  logic clk,
  input  logic rst_n,
  input  logic halt_req,
  input  logic stop_req,
  input  logic irq_release,
  input  logic wait_release,
  output logic halt_q,
  output logic stop_q,
  output logic wait_q
);

  logic halt_d, stop_d, wait_d;

  always_comb begin
    halt_d = halt_q;
    stop_d = stop_q;
    wait_d = wait_q;
    if (irq_release) begin
      halt_d = 1'b0;
      stop_d = 1'b0;
    end else begin
      if (halt_req) halt_d = 1'b1;
      if (stop_req) stop_d = 1'b1;
    end
    if (irq_release && stop_q) wait_d = 1'b1;
    else if (wait_release)     wait_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q <= 1'b0;
      stop_q <= 1'b0;
      wait_q <= 1'b0;
    end else begin
      halt_q <= halt_d;
      stop_q <= stop_d;
      wait_q <= wait_d;
    end
  end

  // R6: release clears both mode flags on the next clock
  a_r6_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
    irq_release |=> (!halt_q && !stop_q));

  // R8: leaving STOP always passes through the settle wait
  a_r8_stop_exit_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && irq_release) |=> wait_q);

endmodule

// File: rtl/cpu_clk_ctrl.sv
`timescale 1ns/1ps
module cpu_clk_ctrl
  import clkc_pkg::*;
#(
  parameter int unsigned N_FAST      = 4,
  parameter int unsigned N_MID       = 8,
  parameter int unsigned N_SLOW      = 64,
  parameter int unsigned N_SUB       = 4,
  parameter int unsigned SYNC_STAGES = 2
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       main_tick,
  input  logic       sub_tick,
  input  logic       pcc_we,
  input  logic [3:0] pcc_wdata,
  input  logic       scc_we,
  input  logic [3:0] scc_wdata,
  input  logic       halt_req,
  input  logic       stop_req,
  input  logic       irq_release,
  input  logic       wait_release,
  output logic       cpu_en,
  output logic       main_osc_dis,
  output logic [3:0] pcc_o,
  output logic [3:0] scc_o
);

  // Reset synchronizer: asynchronous assert, synchronous release
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_s_n;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_rst_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_pipe[g] <= 1'b0;
        else        rst_pipe[g] <= 1'b1;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_pipe[g] <= 1'b0;
        else        rst_pipe[g] <= rst_pipe[g-1];
      end
    end
  end
  assign rst_s_n = rst_pipe[SYNC_STAGES-1];

  clk_cfg_t cfg_req;
  logic     osc_off;
  logic     halt_q, stop_q, wait_q;
  logic     boundary;
  logic     tick_main_g;
  logic     cpu_en_d;

  clkc_regs u_regs (
    .clk           (clk),
    .rst_n         (rst_s_n),
    .pcc_we        (pcc_we),
    .pcc_div_wdata (pcc_wdata[1:0]),
    .scc_we        (scc_we),
    .scc_src_wdata (scc_wdata[0]),
    .scc_off_wdata (scc_wdata[3]),
    .cfg_req       (cfg_req),
    .osc_off       (osc_off)
  );

  clkc_standby u_standby (
    .clk          (clk),
    .rst_n        (rst_s_n),
    .halt_req     (halt_req),
    .stop_req     (stop_req),
    .irq_release  (irq_release),
    .wait_release (wait_release),
    .halt_q       (halt_q),
    .stop_q       (stop_q),
    .wait_q       (wait_q)
  );

  clkc_divider #(
    .N_FAST (N_FAST),
    .N_MID  (N_MID),
    .N_SLOW (N_SLOW),
    .N_SUB  (N_SUB)
  ) u_div (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .tick_main (tick_main_g),
    .tick_sub  (sub_tick),
    .cfg_req   (cfg_req),
    .boundary  (boundary)
  );

  always_comb begin
    main_osc_dis = stop_q || osc_off;
    tick_main_g  = main_tick && !main_osc_dis;
    cpu_en_d     = boundary && !halt_q && !stop_q && !wait_q;
    pcc_o        = {stop_q, halt_q, cfg_req.mdiv};
    scc_o        = {osc_off, 2'b00, cfg_req.src_sub};
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) cpu_en <= 1'b0;
    else          cpu_en <= cpu_en_d;
  end

  // R4: the enable is a single-cycle pulse
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_s_n)
    cpu_en |=> !cpu_en);

  // R5: a held HALT flag suppresses the enable
  a_r5_halt_blocks_en: assert property (@(posedge clk) disable iff (!rst_s_n)
    halt_q |=> !cpu_en);

  // R7: STOP forces the main oscillator off
  a_r7_stop_osc_off: assert property (@(posedge clk) disable iff (!rst_s_n)
    stop_q |-> main_osc_dis);

  // R8: the settle wait suppresses the enable
  a_r8_wait_blocks_en: assert property (@(posedge clk) disable iff (!rst_s_n)
    wait_q |=> !cpu_en);

  // R9: the register's oscillator-off bit alone reaches the output
  a_r9_scc_osc_off: assert property (@(posedge clk) disable iff (!rst_s_n)
    scc_o[3] |-> main_osc_dis);

endmodule

// File: tb/tb_cpu_clk_ctrl.sv
`timescale 1ns/1ps
module tb_cpu_clk_ctrl;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       main_tick, sub_tick;
  logic       pcc_we, scc_we;
  logic [3:0] pcc_wdata, scc_wdata;
  logic       halt_req, stop_req, irq_release, wait_release;
  logic       cpu_en, main_osc_dis;
  logic [3:0] pcc_o, scc_o;

  localparam int MAIN_PER = 2;
  localparam int SUB_PER  = 16;

  cpu_clk_ctrl dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .main_tick    (main_tick),
    .sub_tick     (sub_tick),
    .pcc_we       (pcc_we),
    .pcc_wdata    (pcc_wdata),
    .scc_we       (scc_we),
    .scc_wdata    (scc_wdata),
    .halt_req     (halt_req),
    .stop_req     (stop_req),
    .irq_release  (irq_release),
    .wait_release (wait_release),
    .cpu_en       (cpu_en),
    .main_osc_dis (main_osc_dis),
    .pcc_o        (pcc_o),
    .scc_o        (scc_o)
  );

  initial forever #2.5 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  int last_pulse   = 0;
  bit have_last    = 1'b0;
  int pulse_total  = 0;
  int exp_q[$];
  string tag_q[$];
  event pulse_ev;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Tick sources, driven at the falling edge
  initial begin
    main_tick = 1'b0;
    sub_tick  = 1'b0;
    forever begin
      @(negedge clk);
      main_tick = ((cyc % MAIN_PER) == 0);
      sub_tick  = ((cyc % SUB_PER) == 3);
    end
  end

  // Monitor: measures the spacing of enable pulses and scores queued expectations
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (cpu_en === 1'b1) begin
        pulse_total++;
        if (have_last && exp_q.size() > 0) begin
          automatic int e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          check((cyc - last_pulse) == e, t, cyc - last_pulse, e);
        end
        last_pulse = cyc;
        have_last  = 1'b1;
        -> pulse_ev;
      end
    end
  end

  // Driver: flush two pulses, then queue n expected intervals and wait for them
  task automatic expect_rate(input int n, input int interval, input string tag);
    @pulse_ev;
    @pulse_ev;
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(interval);
      tag_q.push_back(tag);
    end
    while (exp_q.size() > 0) @(negedge clk);
  endtask

  task automatic wr_pcc(input logic [3:0] v);
    pcc_we = 1'b1; pcc_wdata = v;
    @(negedge clk);
    pcc_we = 1'b0;
  endtask

  task automatic wr_scc(input logic [3:0] v);
    scc_we = 1'b1; scc_wdata = v;
    @(negedge clk);
    scc_we = 1'b0;
  endtask

  task automatic pulse_halt();
    halt_req = 1'b1; @(negedge clk); halt_req = 1'b0;
  endtask

  task automatic pulse_stop();
    stop_req = 1'b1; @(negedge clk); stop_req = 1'b0;
  endtask

  task automatic pulse_irq();
    irq_release = 1'b1; @(negedge clk); irq_release = 1'b0;
  endtask

  task automatic pulse_wait();
    wait_release = 1'b1; @(negedge clk); wait_release = 1'b0;
  endtask

  // Counts enable pulses over a window after a short settle
  task automatic quiet_window(input int len, input string tag);
    automatic int start;
    repeat (4) @(negedge clk);
    start = pulse_total;
    repeat (len) @(negedge clk);
    check(pulse_total == start, tag, pulse_total - start, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    pcc_we = 1'b0; scc_we = 1'b0; pcc_wdata = '0; scc_wdata = '0;
    halt_req = 1'b0; stop_req = 1'b0; irq_release = 1'b0; wait_release = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state and slowest main rate
    check(pcc_o == 4'b0000, "R1 pcc", pcc_o, 0);
    check(scc_o == 4'b0000, "R1 scc", scc_o, 0);
    check(main_osc_dis == 1'b0, "R1 osc", main_osc_dis, 0);
    expect_rate(2, 64 * MAIN_PER, "R1 rate");

    // R2: main divide encoding
    wr_pcc(4'b0011); expect_rate(3, 4 * MAIN_PER, "R2 code11");
    wr_pcc(4'b0010); expect_rate(3, 8 * MAIN_PER, "R2 code10");
    wr_pcc(4'b0001); expect_rate(2, 64 * MAIN_PER, "R2 code01");
    wr_pcc(4'b0000); expect_rate(2, 64 * MAIN_PER, "R2 code00");

    // R4: change mid-cycle from /4 to /64 gives one full old then full new intervals
    wr_pcc(4'b0011); expect_rate(1, 4 * MAIN_PER, "R4 setup");
    @pulse_ev;
    exp_q.push_back(4 * MAIN_PER);  tag_q.push_back("R4 old");
    exp_q.push_back(64 * MAIN_PER); tag_q.push_back("R4 new");
    exp_q.push_back(64 * MAIN_PER); tag_q.push_back("R4 new");
    repeat (2) @(negedge clk);
    wr_pcc(4'b0000);
    while (exp_q.size() > 0) @(negedge clk);

    // R10: upper write bits ignored, scc unused bits read zero
    wr_pcc(4'b1110);
    check(pcc_o == 4'b0010, "R10 pcc", pcc_o, 4'b0010);
    expect_rate(2, 8 * MAIN_PER, "R10 running");
    wr_scc(4'b0110);
    check(scc_o == 4'b0000, "R10 scc", scc_o, 0);

    // R3: subsystem source
    wr_scc(4'b0001);
    check(scc_o == 4'b0001, "R3 scc", scc_o, 1);
    expect_rate(3, 4 * SUB_PER, "R3 sub");

    // R9: oscillator-off bit; subsystem keeps running, main stalls
    wr_scc(4'b1001);
    check(main_osc_dis == 1'b1, "R9 osc", main_osc_dis, 1);
    expect_rate(2, 4 * SUB_PER, "R9 sub runs");
    wr_scc(4'b1000);
    repeat (200) @(negedge clk);
    quiet_window(400, "R9 main stalled");
    wr_scc(4'b0000);
    check(main_osc_dis == 1'b0, "R9 osc on", main_osc_dis, 0);
    expect_rate(2, 8 * MAIN_PER, "R9 resume");

    // R5: HALT
    wr_pcc(4'b0011);
    expect_rate(1, 4 * MAIN_PER, "R5 setup");
    pulse_halt();
    check(pcc_o[3:2] == 2'b01, "R5 flag", pcc_o[3:2], 1);
    check(main_osc_dis == 1'b0, "R5 osc", main_osc_dis, 0);
    quiet_window(300, "R5 no enable");

    // R6: release clears HALT
    pulse_irq();
    check(pcc_o[2] == 1'b0, "R6 halt clr", pcc_o[2], 0);
    expect_rate(2, 4 * MAIN_PER, "R6 resume");

    // R6: release wins over a same-cycle request
    halt_req = 1'b1; irq_release = 1'b1;
    @(negedge clk);
    halt_req = 1'b0; irq_release = 1'b0;
    check(pcc_o[2] == 1'b0, "R6 priority", pcc_o[2], 0);
    expect_rate(2, 4 * MAIN_PER, "R6 not halted");

    // R7: STOP
    pulse_stop();
    check(pcc_o[3] == 1'b1, "R7 flag", pcc_o[3], 1);
    check(main_osc_dis == 1'b1, "R7 osc", main_osc_dis, 1);
    quiet_window(300, "R7 no enable");

    // R8: release clears STOP but holds until settle signal
    pulse_irq();
    check(pcc_o[3] == 1'b0, "R6 stop clr", pcc_o[3], 0);
    check(main_osc_dis == 1'b0, "R8 osc on", main_osc_dis, 0);
    quiet_window(300, "R8 held");
    pulse_wait();
    expect_rate(3, 4 * MAIN_PER, "R8 resume");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule